// File: doc/BRIEF.md
# Dual-Priority Read-to-Clear Interrupt Latch

This block gathers 32 peripheral interrupt sources and records each rising edge in one of two latch registers: a high-priority latch or a low-priority latch. A per-channel priority select picks the latch for each channel. A per-channel mask decides whether a channel is captured at all. Each latch drives its own combined interrupt line, so many channels can share one line. The service routine reads the latch to find out which channels fired.

Software reaches the block through a plain address/strobe register port. A read of either main latch returns its contents and clears it in the same step. Each latch also has a shadow address. A shadow read returns the same data but leaves the latch alone, so a debugger can look at pending interrupts without acknowledging them. When a new edge arrives in the same cycle that a read clears the latch, the new edge wins and stays latched.

Top module: `dual_prio_irq_latch`

## Requirements
- R1: After reset, both latches, both interrupt outputs, `rdData`, the priority-select register and the mask register are all zero.
- R2: Each source passes through a two-flop synchroniser. A rising edge is latched at the third rising clock edge after the source goes high. A source that stays high is captured only once: after a clear it is not latched again until it goes low and then high.
- R3: A channel whose priority-select bit is 1 is latched into the high latch. A channel whose bit is 0 is latched into the low latch. Bit n of each latch is channel n.
- R4: A channel whose mask bit is 0 is not latched. An edge that arrives while the channel is masked is lost and is not recovered when the mask bit is later set to 1.
- R5: A read at address 0 returns the high latch and clears every bit of the high latch.
- R6: A read at address 1 returns the low latch and clears every bit of the low latch.
- R7: Reads at address 2 (high shadow) and address 3 (low shadow) return exactly what a read at address 0 or 1 would return. They clear nothing and leave the interrupt outputs unchanged.
- R8: If a channel edge is captured on the same clock edge as a clearing read of its latch, the read returns the old contents and the new bit stays latched.
- R9: `irqHigh` is high exactly when any bit of the high latch is set, and `irqLow` is high exactly when any bit of the low latch is set. Each stays high until its latch is cleared.
- R10: Address 4 is the priority-select register and address 5 is the mask register. Both are written with `wrEn` and both read back what was written. A read at address 6 or 7 returns zero and changes no state.
- R11: Read data appears on `rdData` on the clock edge that samples `rdEn`. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcIn | input | 32 | Asynchronous interrupt source levels, one per channel |
| rdEn | input | 1 | Read strobe, one cycle per read |
| wrEn | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irqHigh | output | 1 | Combined high-priority interrupt |
| irqLow | output | 1 | Combined low-priority interrupt |

## Verification
The tests send edges on channels that are steered to each priority at the same time. This shows whether the priority select routes each bit to the right latch, and whether each bit appears at the right position in that latch. Shadow reads are repeated and then followed by a clearing read, which shows the difference between a read with side effects and one without. One source is held high across a clear to show that capture is edge based and not level based. Another is masked while it toggles, to show that an edge caught while masked is lost. One edge is timed to land on the clearing read itself, which checks that a new set wins over the clear.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_HIGH_CLR  = 3'd0,
    REG_LOW_CLR   = 3'd1,
    REG_HIGH_PEEK = 3'd2,
    REG_LOW_PEEK  = 3'd3,
    REG_PRIO_SEL  = 3'd4,
    REG_MASK      = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic                  rdStrobe;
    logic [REG_ADDR_W-1:0] rdSel;
    logic                  clrHigh;
    logic                  clrLow;
    logic                  wrPrio;
    logic                  wrMask;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
(
  input  logic                  rdEn,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] addr,
  output ctrlStrobes_t          ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.rdStrobe = rdEn;
    ctrl.rdSel    = addr;
    ctrl.clrHigh  = rdEn && (addr == REG_HIGH_CLR);
    ctrl.clrLow   = rdEn && (addr == REG_LOW_CLR);
    ctrl.wrPrio   = wrEn && (addr == REG_PRIO_SEL);
    ctrl.wrMask   = wrEn && (addr == REG_MASK);
  end

endmodule

// File: rtl/irq_latch_datapath.sv
module irq_latch_datapath
  import irq_latch_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] srcIn,
  input  ctrlStrobes_t      ctrl,
  input  logic [NUM_CH-1:0] wrData,
  output logic [NUM_CH-1:0] setHigh,
  output logic [NUM_CH-1:0] setLow,
  output logic [NUM_CH-1:0] latchHigh,
  output logic [NUM_CH-1:0] latchLow,
  output logic [NUM_CH-1:0] rdData,
  output logic              irqHigh,
  output logic              irqLow
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_CH-1:0] syncPipe;
  logic [NUM_CH-1:0] syncPrev;
  logic [NUM_CH-1:0] riseEdge;
  logic [NUM_CH-1:0] prioSel;
  logic [NUM_CH-1:0] chanMask;
  logic [NUM_CH-1:0] rdMux;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncPipe[s] <= '0;
        else        syncPipe[s] <= srcIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncPipe[s] <= '0;
        else        syncPipe[s] <= syncPipe[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncPrev <= '0;
    else        syncPrev <= syncPipe[LAST_STAGE];
  end

  assign riseEdge = syncPipe[LAST_STAGE] & ~syncPrev & chanMask;
  assign setHigh  = riseEdge & prioSel;
  assign setLow   = riseEdge & ~prioSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prioSel  <= '0;
      chanMask <= '0;
    end else begin
      if (ctrl.wrPrio) prioSel  <= wrData;
      if (ctrl.wrMask) chanMask <= wrData;
    end
  end

  // A set in the same cycle beats the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchHigh <= '0;
      latchLow  <= '0;
    end else begin
      latchHigh <= (ctrl.clrHigh ? '0 : latchHigh) | setHigh;
      latchLow  <= (ctrl.clrLow  ? '0 : latchLow)  | setLow;
    end
  end

  always_comb begin
    case (ctrl.rdSel)
      REG_HIGH_CLR, REG_HIGH_PEEK: rdMux = latchHigh;
      REG_LOW_CLR,  REG_LOW_PEEK:  rdMux = latchLow;
      REG_PRIO_SEL:                rdMux = prioSel;
      REG_MASK:                    rdMux = chanMask;
      default:                     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rdData <= '0;
    else if (ctrl.rdStrobe) rdData <= rdMux;
  end

  assign irqHigh = |latchHigh;
  assign irqLow  = |latchLow;

endmodule

// File: rtl/dual_prio_irq_latch.sv
module dual_prio_irq_latch
  import irq_latch_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     srcIn,
  input  logic                  rdEn,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0]     wrData,
  output logic [NUM_CH-1:0]     rdData,
  output logic                  irqHigh,
  output logic                  irqLow
);

  ctrlStrobes_t      ctrl;
  logic [NUM_CH-1:0] setHigh;
  logic [NUM_CH-1:0] setLow;
  logic [NUM_CH-1:0] latchHigh;
  logic [NUM_CH-1:0] latchLow;

  irq_latch_ctrl u_ctrl (
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .ctrl (ctrl)
  );

  irq_latch_datapath #(
    .NUM_CH      (NUM_CH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .srcIn     (srcIn),
    .ctrl      (ctrl),
    .wrData    (wrData),
    .setHigh   (setHigh),
    .setLow    (setLow),
    .latchHigh (latchHigh),
    .latchLow  (latchLow),
    .rdData    (rdData),
    .irqHigh   (irqHigh),
    .irqLow    (irqLow)
  );

endmodule

// File: rtl/dual_prio_irq_latch_chk.sv
module dual_prio_irq_latch_chk
  import irq_latch_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rdEn,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0]     rdData,
  input logic                  irqHigh,
  input logic                  irqLow,
  input logic [NUM_CH-1:0]     setHigh,
  input logic [NUM_CH-1:0]     setLow,
  input logic [NUM_CH-1:0]     latchHigh
);

  localparam logic [REG_ADDR_W-1:0] A_HCLR  = REG_HIGH_CLR;
  localparam logic [REG_ADDR_W-1:0] A_HPEEK = REG_HIGH_PEEK;
  localparam logic [REG_ADDR_W-1:0] A_LPEEK = REG_LOW_PEEK;

  // R3: a channel is steered to only one latch
  p_single_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (setHigh & setLow) == '0);

  // R5: after a clearing read only fresh sets remain
  p_clear_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == A_HCLR) |=> (latchHigh & ~$past(setHigh)) == '0);

  // R7: a shadow read keeps the interrupt lines up
  p_peek_keeps_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == A_HPEEK && irqHigh) |=> irqHigh);

  p_peek_keeps_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == A_LPEEK && irqLow) |=> irqLow);

  // R7: the high shadow returns the latch contents
  p_peek_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == A_HPEEK) |=> rdData == $past(latchHigh));

  // R8: a set wins against a same-cycle clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == A_HCLR && setHigh != '0) |=> irqHigh);

endmodule

bind dual_prio_irq_latch dual_prio_irq_latch_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdData    (rdData),
  .irqHigh   (irqHigh),
  .irqLow    (irqLow),
  .setHigh   (setHigh),
  .setLow    (setLow),
  .latchHigh (latchHigh)
);

// File: tb/dual_prio_irq_latch_tb.sv
module dual_prio_irq_latch_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] srcIn = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqHigh;
  logic        irqLow;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  dual_prio_irq_latch u_dut (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .irqHigh(irqHigh), .irqLow(irqLow)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  // raise bits, wait for capture, drop them and let the synchroniser settle
  task automatic pulseSrc(input logic [31:0] bits);
    @(negedge clk);
    srcIn = srcIn | bits;
    repeat (3) @(negedge clk);
    srcIn = srcIn & ~bits;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check(rdData == 0, "R1 rdData", rdData, 0);
    check(irqHigh == 0 && irqLow == 0, "R1 irq", {30'd0, irqHigh, irqLow}, 0);
    doRead(3'd4, d); check(d == 0, "R1 prio", d, 0);
    doRead(3'd5, d); check(d == 0, "R1 mask", d, 0);
    doRead(3'd0, d); check(d == 0, "R1 high latch", d, 0);
  endtask

  task automatic testConfig();
    logic [31:0] d;
    doWrite(3'd4, 32'hFFFF_0000);
    doWrite(3'd5, 32'hFFFF_FFFF);
    doRead(3'd4, d); check(d == 32'hFFFF_0000, "R10 prio readback", d, 32'hFFFF_0000);
    doRead(3'd5, d); check(d == 32'hFFFF_FFFF, "R10 mask readback", d, 32'hFFFF_FFFF);
    doRead(3'd6, d); check(d == 0, "R10 unmapped 6", d, 0);
    doRead(3'd7, d); check(d == 0, "R10 unmapped 7", d, 0);
  endtask

  task automatic testTiming();
    logic [31:0] d;
    @(negedge clk);
    srcIn[20] = 1'b1;
    @(negedge clk);
    check(irqHigh == 0, "R2 not before third edge (1)", {31'd0, irqHigh}, 0);
    @(negedge clk);
    check(irqHigh == 0, "R2 not before third edge (2)", {31'd0, irqHigh}, 0);
    @(negedge clk);
    check(irqHigh == 1, "R2 latched at third edge", {31'd0, irqHigh}, 1);
    srcIn[20] = 1'b0;
    repeat (3) @(negedge clk);
    doRead(3'd0, d); check(d == 32'h0010_0000, "R2 bit 20", d, 32'h0010_0000);
  endtask

  task automatic testSteerAndPeek();
    logic [31:0] d;
    logic [31:0] held;
    pulseSrc(32'h0001_0001);
    check(irqHigh == 1 && irqLow == 1, "R9 both lines", {30'd0, irqHigh, irqLow}, 3);
    doRead(3'd2, d); check(d == 32'h0001_0000, "R3 high shadow", d, 32'h0001_0000);
    doRead(3'd3, d); check(d == 32'h0000_0001, "R3 low shadow", d, 32'h0000_0001);
    doRead(3'd2, d); check(d == 32'h0001_0000, "R7 repeat shadow", d, 32'h0001_0000);
    check(irqHigh == 1 && irqLow == 1, "R7 lines kept", {30'd0, irqHigh, irqLow}, 3);
    doRead(3'd6, d);
    check(irqHigh == 1 && irqLow == 1, "R10 unmapped read no clear",
          {30'd0, irqHigh, irqLow}, 3);
    // R11: the value on rdData holds until a new read strobe
    doRead(3'd0, d);
    held = d;
    check(d == 32'h0001_0000, "R5 high read", d, 32'h0001_0000);
    check(irqHigh == 0 && irqLow == 1, "R5 only high cleared",
          {30'd0, irqHigh, irqLow}, 1);
    repeat (4) @(negedge clk);
    check(rdData == held, "R11 rdData holds", rdData, held);
    @(negedge clk);
    rdEn = 1'b1; addr = 3'd1;
    #1;
    check(rdData == held, "R11 no change before edge", rdData, held);
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData == 32'h1, "R6 low read", rdData, 32'h1);
    check(irqLow == 0, "R6 low cleared", {31'd0, irqLow}, 0);
    doRead(3'd2, d); check(d == 0, "R5 high empty", d, 0);
  endtask

  task automatic testMaskAndLevel();
    logic [31:0] d;
    doWrite(3'd5, 32'hFFFF_FFFE);
    pulseSrc(32'h1);
    check(irqLow == 0, "R4 masked line", {31'd0, irqLow}, 0);
    doWrite(3'd5, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    doRead(3'd3, d); check(d == 0, "R4 lost edge", d, 0);
    @(negedge clk);
    srcIn[1] = 1'b1;
    repeat (3) @(negedge clk);
    doRead(3'd1, d); check(d == 32'h2, "R2 level first capture", d, 32'h2);
    repeat (5) @(negedge clk);
    check(irqLow == 0, "R2 level no recapture", {31'd0, irqLow}, 0);
    srcIn[1] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testSetWins();
    logic [31:0] d;
    pulseSrc(32'h0001_0000);
    @(negedge clk);
    srcIn[17] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rdEn = 1'b1; addr = 3'd0;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData == 32'h0001_0000, "R8 read returns old", rdData, 32'h0001_0000);
    check(irqHigh == 1, "R8 line stays", {31'd0, irqHigh}, 1);
    doRead(3'd0, d); check(d == 32'h0002_0000, "R8 new bit kept", d, 32'h0002_0000);
    srcIn[17] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testConfig();
    testTiming();
    testSteerAndPeek();
    testMaskAndLevel();
    testSetWins();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule